// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counter channel behind a byte-wide register port. The host writes a control byte to pick one of six output behaviours and either binary or four-digit BCD arithmetic. It then writes the initial count as two data bytes, low byte first. From then on the channel counts down once for each cycle in which `tick` is high. The `gate` input either pauses counting or, in the triggered modes, starts and restarts it. The channel drives `out` according to the selected behaviour.

The host reads the count through a latch command, which freezes the value for a two-byte read. It can also issue a status command, which makes the next read return a status byte. All inputs are synchronous to `clk`. `tick` is a count-enable strobe, not a separate clock.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is low, the channel is in mode 0 with binary counting, and a status read returns 0x40.
- R2: Control byte bits [7:6] select the command: 00 programs the channel, 01 latches the count, 10 requests status, and 11 has no effect. In a program byte, bits [3:1] give the mode (codes 6 and 7 act as modes 2 and 3) and bit 0 set selects BCD. Programming stops counting until a new count is transferred. It also sets `out` low in mode 0 and high in every other mode.
- R3: Data bytes are taken low then high. The count moves into the counter on the first tick after the high byte is written in modes 0, 2, 3 and 4. In modes 1 and 5 it moves on the first tick after a gate rising edge. The null-count flag is set from programming or count writing until that transfer.
- R4: An initial count of zero means 65536 in binary and 10000 in BCD. In BCD each nibble is one decimal digit and decrements borrow decimally (0x0100 becomes 0x0099).
- R5: In modes 0, 1, 4 and 5, a count of zero decrements to 0xFFFF in binary or 0x9999 in BCD, and counting continues.
- R6: A latch command freezes the count. The next two reads return its low byte and then its high byte. A further latch command before both bytes are read is ignored. Without a latch, reads return the live count, low byte first.
- R7: A status command makes only the next read return {out, null-count, control byte bits [5:0] of the last program byte}, bit 7 first.
- R8: Mode 0: `out` stays low after the count is written and goes high when the count reaches zero. It stays high until the channel is reprogrammed or a new count is written.
- R9: Mode 1: a gate rising edge loads the count and drives `out` low on the next tick. `out` goes high when the count reaches zero. A new rising edge reloads the count.
- R10: Mode 2: `out` is high and goes low for the one tick interval while the count is 1. The next tick reloads the initial count and drives `out` high again.
- R11: Mode 3: `out` is high while the count is above half the initial count (half rounded down) and low otherwise. The counter reloads after 1, so an odd count gives the extra tick to the high phase.
- R12: Modes 4 and 5: `out` is high except for the one tick interval in which the count is zero. Mode 5 starts only from a gate rising edge.
- R13: In modes 0, 2, 3 and 4 a low `gate` holds the count. The count transfer still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe |
| gate | input | 1 | Gate: count qualifier or trigger |
| wr_en | input | 1 | Byte write strobe |
| wr_ctrl | input | 1 | 1 = control byte, 0 = count data byte |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read strobe; advances the read sequence |
| rd_data | output | 8 | Byte presented for the current read |
| out | output | 1 | Channel output |

## Verification
The hardest states to reach are the ones that exist only between ticks. One is the wrap from zero to the all-nines or all-ones value. Others are the reload point of the periodic modes and a retrigger that lands while a one-shot is still counting. The stimulus reaches them with short initial counts and single-tick steps. It reads `out`, or a frozen count through a latch command, after every step. The square-wave test uses a decimal count of 10 so that a binary halving of the count cannot pass by accident.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DIGITS = CNT_W / 4;
    localparam int EXT_W  = CNT_W + 1;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        CMD_PROG   = 2'd0,
        CMD_LATCH  = 2'd1,
        CMD_STATUS = 2'd2,
        CMD_NONE   = 2'd3
    } cmd_e;

    typedef struct packed {
        mode_e mode;
        logic  bcd;
    } cfg_t;

    function automatic mode_e decode_mode(input logic [2:0] f);
        if (f[2] && f[1]) return mode_e'({1'b0, f[1:0]});
        return mode_e'(f);
    endfunction

    function automatic logic hw_trig(input mode_e m);
        return (m == M_ONESHOT) || (m == M_HWSTROBE);
    endfunction

    function automatic logic periodic(input mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic [EXT_W-1:0] bcd_dec(input logic [EXT_W-1:0] v);
        logic [EXT_W-1:0] r;
        logic b;
        r = v;
        b = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (b) begin
                if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
                else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    b = 1'b0;
                end
            end
        end
        if (b) r[CNT_W] = 1'b0;
        return r;
    endfunction

    function automatic logic [EXT_W-1:0] bcd_half(input logic [EXT_W-1:0] v);
        logic [EXT_W-1:0] r;
        logic rem;
        logic [4:0] t;
        r = '0;
        rem = v[CNT_W];
        for (int i = DIGITS - 1; i >= 0; i--) begin
            t = (rem ? 5'd10 : 5'd0) + {1'b0, v[4*i +: 4]};
            r[4*i +: 4] = t[4:1];
            rem = t[0];
        end
        return r;
    endfunction

    function automatic logic [EXT_W-1:0] count_down(input logic [EXT_W-1:0] v,
                                                    input logic bcd);
        if (v == '0) return bcd ? {1'b0, {DIGITS{4'h9}}} : {1'b0, {CNT_W{1'b1}}};
        return bcd ? bcd_dec(v) : v - 1'b1;
    endfunction
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              null_cnt,
    output logic              prog_stb,
    output cfg_t              prog_cfg,
    output logic              load_stb,
    output logic [CNT_W-1:0]  init_val
);
    cmd_e              cmd;
    logic [5:0]        ctrl_q;
    logic              wr_hi;
    logic [BYTE_W-1:0] lo_q;
    logic              latch_vld;
    logic [CNT_W-1:0]  latch_q;
    logic              rd_hi;
    logic              stat_vld;
    logic [BYTE_W-1:0] stat_q;
    logic [CNT_W-1:0]  src;

    assign cmd           = cmd_e'(wr_data[7:6]);
    assign prog_stb      = wr_en && wr_ctrl && (cmd == CMD_PROG);
    assign prog_cfg.mode = decode_mode(wr_data[3:1]);
    assign prog_cfg.bcd  = wr_data[0];
    assign load_stb      = wr_en && !wr_ctrl && wr_hi;
    assign init_val      = {wr_data, lo_q};

    assign src     = latch_vld ? latch_q : live_cnt;
    assign rd_data = stat_vld ? stat_q : (rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            wr_hi     <= 1'b0;
            lo_q      <= '0;
            latch_vld <= 1'b0;
            latch_q   <= '0;
            rd_hi     <= 1'b0;
            stat_vld  <= 1'b0;
            stat_q    <= '0;
        end else begin
            if (wr_en && wr_ctrl) begin
                case (cmd)
                    CMD_PROG: begin
                        ctrl_q    <= wr_data[5:0];
                        wr_hi     <= 1'b0;
                        rd_hi     <= 1'b0;
                        latch_vld <= 1'b0;
                        stat_vld  <= 1'b0;
                    end
                    CMD_LATCH: if (!latch_vld) begin
                        latch_vld <= 1'b1;
                        latch_q   <= live_cnt;
                        rd_hi     <= 1'b0;
                    end
                    CMD_STATUS: if (!stat_vld) begin
                        stat_vld <= 1'b1;
                        stat_q   <= {out_lvl, null_cnt, ctrl_q};
                    end
                    default: ;
                endcase
            end else if (wr_en) begin
                if (!wr_hi) lo_q <= wr_data;
                wr_hi <= !wr_hi;
            end
            if (rd_en) begin
                if (stat_vld) stat_vld <= 1'b0;
                else if (rd_hi) begin
                    rd_hi     <= 1'b0;
                    latch_vld <= 1'b0;
                end else rd_hi <= 1'b1;
            end
        end
    end

    // R7: a status byte is returned once only
    p_status_once_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_vld && rd_en && !wr_en) |=> !stat_vld);

    // R6: a frozen count does not change without a write
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (latch_vld && !wr_en) |=> $stable(latch_q));
endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             prog_stb,
    input  cfg_t             prog_cfg,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_out,
    output logic             out,
    output logic             null_cnt
);
    localparam logic [EXT_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    cfg_t             cfg_q;
    logic [EXT_W-1:0] cnt_q;
    logic [CNT_W-1:0] init_q;
    logic             have_cnt, load_pend, trig_pend, armed, gate_q, out_q, null_q;
    logic [EXT_W-1:0] ext_init, half, nxt;
    logic             hw, gate_rise, transfer, run;

    assign hw        = hw_trig(cfg_q.mode);
    assign ext_init  = (init_q == '0) ? FULL : {1'b0, init_q};
    assign half      = cfg_q.bcd ? bcd_half(ext_init) : (ext_init >> 1);
    assign nxt       = count_down(cnt_q, cfg_q.bcd);
    assign gate_rise = gate && !gate_q;
    assign transfer  = tick && (hw ? trig_pend : load_pend);
    assign run       = tick && armed && (hw || gate) && !transfer;

    assign cnt_out  = cnt_q[CNT_W-1:0];
    assign out      = out_q;
    assign null_cnt = null_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{mode: M_TERM, bcd: 1'b0};
            cnt_q     <= '0;
            init_q    <= '0;
            have_cnt  <= 1'b0;
            load_pend <= 1'b0;
            trig_pend <= 1'b0;
            armed     <= 1'b0;
            gate_q    <= 1'b0;
            out_q     <= 1'b0;
            null_q    <= 1'b1;
        end else begin
            gate_q <= gate;
            if (prog_stb) begin
                cfg_q     <= prog_cfg;
                have_cnt  <= 1'b0;
                load_pend <= 1'b0;
                trig_pend <= 1'b0;
                armed     <= 1'b0;
                null_q    <= 1'b1;
                out_q     <= (prog_cfg.mode != M_TERM);
            end else begin
                if (transfer) begin
                    cnt_q     <= ext_init;
                    armed     <= 1'b1;
                    null_q    <= 1'b0;
                    load_pend <= 1'b0;
                    trig_pend <= 1'b0;
                    out_q     <= (cfg_q.mode != M_TERM) && (cfg_q.mode != M_ONESHOT);
                end else if (run) begin
                    if (periodic(cfg_q.mode) && cnt_q == EXT_W'(1)) begin
                        cnt_q <= ext_init;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= nxt;
                        case (cfg_q.mode)
                            M_TERM, M_ONESHOT: out_q <= out_q || (nxt == '0);
                            M_RATE:            out_q <= (nxt != EXT_W'(1));
                            M_SQUARE:          out_q <= (nxt > half);
                            default:           out_q <= (nxt != '0);
                        endcase
                    end
                end
                if (load_stb) begin
                    init_q   <= init_val;
                    have_cnt <= 1'b1;
                    null_q   <= 1'b1;
                    if (!hw) load_pend <= 1'b1;
                    if (cfg_q.mode == M_TERM) out_q <= 1'b0;
                end
                if (gate_rise && hw && have_cnt) trig_pend <= 1'b1;
            end
        end
    end

    // R8: mode 0 output stays high until rewritten
    p_mode0_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == M_TERM && out_q && !prog_stb && !load_stb) |=> out_q);

    // R10: mode 2 low phase lasts one tick interval
    p_rate_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == M_RATE && armed && !out_q && tick && gate && !prog_stb) |=> out_q);

    // R12: strobe low phase lasts one tick interval
    p_strobe_one_r12: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode == M_SWSTROBE || cfg_q.mode == M_HWSTROBE) && armed && !out_q && tick
         && (gate || hw) && !prog_stb) |=> out_q);

    // R13: low gate holds the count in gated modes
    p_gate_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!hw && !gate && !load_pend && !prog_stb) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              out
);
    logic             prog_stb, load_stb, null_cnt;
    cfg_t             prog_cfg;
    logic [CNT_W-1:0] init_val, live_cnt;

    pit_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .live_cnt (live_cnt),
        .out_lvl  (out),
        .null_cnt (null_cnt),
        .prog_stb (prog_stb),
        .prog_cfg (prog_cfg),
        .load_stb (load_stb),
        .init_val (init_val)
    );

    pit_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .gate     (gate),
        .prog_stb (prog_stb),
        .prog_cfg (prog_cfg),
        .load_stb (load_stb),
        .init_val (init_val),
        .cnt_out  (live_cnt),
        .out      (out),
        .null_cnt (null_cnt)
    );
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
    logic       clk = 1'b0;
    logic       rst, tick, gate, wr_en, wr_ctrl, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       out;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pit_channel dut (.clk(clk), .rst(rst), .tick(tick), .gate(gate), .wr_en(wr_en),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .out(out));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [7:0] b);
        wr_en = 1'b1; wr_ctrl = c; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        b = rd_data; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic trig();
        gate = 1'b0; @(negedge clk);
        gate = 1'b1; @(negedge clk);
    endtask

    task automatic load(input logic [7:0] m, input logic [15:0] v);
        wr(1'b1, m); wr(1'b0, v[7:0]); wr(1'b0, v[15:8]);
    endtask

    task automatic latched(output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(1'b1, 8'h40); rd(lo); rd(hi);
        v = {hi, lo};
    endtask

    task automatic status(output logic [7:0] s);
        wr(1'b1, 8'h80); rd(s);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check("R1 out", out, 0);
        status(s); check("R1 status", s, 8'h40);
    endtask

    task automatic t_status();
        logic [7:0] s;
        load(8'h36, 16'd4);
        status(s); check("R7 status before transfer", s, 8'hF6);
        ticks(1);
        status(s); check("R7 R3 status after transfer", s, 8'hB6);
        rd(s); check("R7 next read is count", s, 8'h04);
    endtask

    task automatic t_mode0();
        logic [7:0] s; logic [15:0] v;
        load(8'h00, 16'd5);
        status(s); check("R3 null before transfer", s, 8'h40);
        ticks(1); latched(v); check("R3 transferred count", v, 5);
        ticks(3); check("R8 out low at count 2", out, 0);
        ticks(1); check("R8 out low at count 1", out, 0);
        ticks(1); check("R8 out high at zero", out, 1);
        ticks(1); latched(v); check("R5 binary wrap", v, 16'hFFFF);
        check("R8 out stays high", out, 1);
    endtask

    task automatic t_gate();
        logic [15:0] v;
        load(8'h00, 16'd3);
        gate = 1'b0; ticks(1); ticks(4);
        latched(v); check("R13 held by gate", v, 3);
        check("R13 out", out, 0);
        gate = 1'b1; ticks(3); check("R13 R8 resumes", out, 1);
    endtask

    task automatic t_latch();
        logic [15:0] v; logic [7:0] b;
        load(8'h00, 16'h1234); ticks(1);
        wr(1'b1, 8'h40); ticks(3); wr(1'b1, 8'h40);
        rd(b); check("R6 latched low", b, 8'h34);
        rd(b); check("R6 latched high", b, 8'h12);
        rd(b); check("R6 live low", b, 8'h31);
        rd(b); check("R6 live high", b, 8'h12);
        v = 0;
    endtask

    task automatic t_bcd();
        logic [15:0] v;
        load(8'h01, 16'h0000); ticks(1); latched(v); check("R4 BCD full", v, 16'h0000);
        ticks(1); latched(v); check("R4 BCD 10000-1", v, 16'h9999);
        load(8'h01, 16'h0100); ticks(2); latched(v); check("R4 BCD borrow", v, 16'h0099);
        load(8'h01, 16'h0001); ticks(3); latched(v); check("R5 BCD wrap", v, 16'h9999);
        load(8'h00, 16'h0000); ticks(2); latched(v); check("R4 binary full", v, 16'hFFFF);
    endtask

    task automatic t_mode2();
        load(8'h04, 16'd4);
        check("R10 out after program", out, 1);
        for (int i = 1; i <= 8; i++) begin
            ticks(1); check("R10 rate pattern", out, ((i - 1) % 4 == 3) ? 0 : 1);
        end
        load(8'h0C, 16'd4); ticks(4); check("R2 code 6 acts as mode 2", out, 0);
    endtask

    task automatic t_mode3();
        load(8'h06, 16'd5);
        for (int i = 1; i <= 10; i++) begin
            ticks(1); check("R11 odd square", out, ((i - 1) % 5 < 3) ? 1 : 0);
        end
        load(8'h06, 16'd4);
        for (int i = 1; i <= 8; i++) begin
            ticks(1); check("R11 even square", out, ((i - 1) % 4 < 2) ? 1 : 0);
        end
        load(8'h07, 16'h0010);
        for (int i = 1; i <= 11; i++) begin
            ticks(1); check("R11 BCD square", out, ((i - 1) % 10 < 5) ? 1 : 0);
        end
    endtask

    task automatic t_mode1();
        logic [7:0] s; logic [15:0] v;
        load(8'h02, 16'd3);
        ticks(2); check("R9 idle out", out, 1);
        status(s); check("R9 R3 waits for trigger", s, 8'hC2);
        trig(); ticks(1); check("R9 triggered low", out, 0);
        ticks(2); check("R9 low at 1", out, 0);
        ticks(1); check("R9 high at zero", out, 1);
        trig(); ticks(2); trig();
        ticks(1); check("R9 retrigger low", out, 0);
        ticks(2); check("R9 retrigger extends", out, 0);
        ticks(1); check("R9 end after retrigger", out, 1);
        ticks(1); latched(v); check("R5 one-shot wrap", v, 16'hFFFF);
    endtask

    task automatic t_mode45();
        logic [7:0] s;
        load(8'h08, 16'd2);
        ticks(2); check("R12 sw before zero", out, 1);
        ticks(1); check("R12 sw strobe", out, 0);
        ticks(1); check("R12 sw after strobe", out, 1);
        load(8'h0A, 16'd2);
        ticks(3); check("R12 hw no trigger", out, 1);
        status(s); check("R12 hw null", s, 8'hCA);
        trig(); ticks(3); check("R12 hw strobe", out, 0);
        ticks(1); check("R12 hw after strobe", out, 1);
    endtask

    task automatic t_prog();
        logic [7:0] s; logic [15:0] v;
        load(8'h00, 16'd9); ticks(3);
        wr(1'b1, 8'h00);
        check("R2 program sets out low", out, 0);
        ticks(3); latched(v); check("R2 counting stopped", v, 16'd7);
        wr(1'b1, 8'hC5);
        status(s); check("R2 reserved command no effect", s, 8'h40);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; gate = 1'b1; wr_en = 1'b0; wr_ctrl = 1'b0;
        wr_data = '0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status();
        t_mode0();
        t_gate();
        t_latch();
        t_bcd();
        t_mode2();
        t_mode3();
        t_mode1();
        t_mode45();
        t_prog();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule